// File: doc/BRIEF.md
# Station Address ROM Validator

This block fetches a network station address from a serially accessed address ROM and decides whether it can be trusted. The ROM sits behind a byte port where each granted read returns the next byte in sequence. After a start strobe the block hunts for a fixed eight-byte synchronisation pattern, or skips the hunt on request. It then reads six address bytes and a two-byte stored checksum.

While the address arrives, the block folds it into a 16-bit end-around checksum. When the last byte has been read, it raises a one-cycle completion pulse. The 48-bit address and a valid flag stay on the outputs until the next start.

An address is rejected in four cases:
- the sync pattern was not found in time,
- the checksum does not match,
- the address has its group (multicast) bit set,
- its vendor prefix is all zeros.

Top module: `station_addr_rom_check`

## Requirements
- R1: After reset `done`, `valid` and `rd_req` are 0 and `mac_addr` is all zeros.
- R2: One ROM byte is consumed on every rising clock edge at which `rd_req` and `rd_ack` are both 1. `rd_req` is 1 only between an accepted start and the completion pulse, and it is 0 while `done` is 1.
- R3: Without skip, incoming bytes are compared against the sync sequence FF, 00, 55, AA, FF, 00, 55, AA. A matching byte advances the match position. A mismatching byte returns the position to the first entry and is not itself compared again against the first entry.
- R4: The hunt reads at most 32 bytes. If the eighth pattern byte is matched on one of those reads, address capture follows. Otherwise `done` pulses with `valid` 0 after exactly 32 reads and no further byte is read.
- R5: With `skip_sync` 1 at the start strobe, no hunt takes place, and the first byte read is address byte 0.
- R6: After sync (or skip), exactly eight bytes are read. These are six address bytes followed by the stored checksum. Address byte k lands in `mac_addr[47-8k -: 8]`, so byte 0 sits in bits 47:40.
- R7: Checksum computation:
  - The sum starts as the little-endian word of bytes 0 and 1.
  - For pairs (2,3) and then (4,5), the sum is first doubled and reduced by 65535 if it exceeds 65535.
  - The little-endian pair word is then added, and the sum is reduced by 65535 if it exceeds 65535.
  - After the last add, the reduction applies when the sum is 65535 or more.
- R8: The stored checksum is read low byte first. If it differs from the computed sum, `valid` is 0.
- R9: `valid` is 0 when bit 0 of address byte 0 is 1 (group address) or when address bytes 0, 1 and 2 are all zero. Otherwise the checksum decides.
- R10: `done` is high for exactly one cycle per run. `valid` and `mac_addr` hold their values from the completion pulse until the next accepted start. A start strobe during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| skip_sync | input | 1 | Sampled with start: bypass the sync hunt |
| rd_ack | input | 1 | ROM byte available on rd_data |
| rd_data | input | 8 | Next ROM byte |
| rd_req | output | 1 | Block wants a ROM byte |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | Address accepted |
| mac_addr | output | 48 | Captured station address, byte 0 in the top octet |

## Verification
The sync hunt is exercised with several ROM layouts:
- junk before a clean pattern,
- a pattern whose last byte is the 32nd read,
- a pattern that ends one read too late,
- no pattern at all,
- a broken prefix (FF 00 55 AA FF FF ...) that only a no-recompare matcher rejects.

The read count tells a bounded, correctly resetting matcher apart from one that re-compares the mismatching byte or reads past the bound.

The checksum is exercised with:
- ordinary addresses,
- a corrupted stored checksum,
- an address chosen so that both mid-pair reductions fire and the final sum lands exactly on 65535, which separates the final greater-or-equal reduction from the strict one.

Group-bit and zero-prefix addresses that carry a correct checksum isolate the two rejection rules from the checksum compare. A start pulse injected mid-run shows that a busy block ignores it.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_ADDR = 2'd2,
    ST_CSUM = 2'd3
  } sar_state_e;

  localparam int          SUM_W   = 17;
  localparam logic [16:0] SUM_MOD = 17'd65535;

  // Sync sequence repeats with period four: FF 00 55 AA.
  function automatic logic [7:0] sync_byte(input int unsigned idx);
    case (idx % 4)
      0:       return 8'hFF;
      1:       return 8'h00;
      2:       return 8'h55;
      default: return 8'hAA;
    endcase
  endfunction

  function automatic logic [16:0] fold_gt(input logic [16:0] v);
    return (v > SUM_MOD) ? (v - SUM_MOD) : v;
  endfunction

  function automatic logic [16:0] fold_ge(input logic [16:0] v);
    return (v >= SUM_MOD) ? (v - SUM_MOD) : v;
  endfunction

endpackage

// File: rtl/sar_sync_hunt.sv
module sar_sync_hunt #(
  parameter int PAT_LEN  = 8,
  parameter int HUNT_MAX = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       beat,
  input  logic [7:0] byte_in,
  output logic       found,
  output logic       exhausted
);
  import sar_pkg::*;

  localparam int IDX_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  localparam int CNT_W = $clog2(HUNT_MAX + 1);

  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit       = (byte_in == sync_byte(int'(idx_q)));
  assign found     = beat && hit && (idx_q == IDX_W'(PAT_LEN - 1));
  assign exhausted = beat && !found && (cnt_q == CNT_W'(HUNT_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (beat) begin
      // A mismatch drops back to the first entry without re-testing.
      idx_q <= hit ? idx_q + 1'b1 : '0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the hunt never counts beyond its read budget
  p_hunt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(HUNT_MAX));

endmodule

// File: rtl/sar_cksum_fold.sv
module sar_cksum_fold (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        beat,
  input  logic        odd,
  input  logic        first_pair,
  input  logic        last_pair,
  input  logic [7:0]  byte_in,
  output logic [15:0] sum_o
);
  import sar_pkg::*;

  logic [SUM_W-1:0] sum_q;
  logic [7:0]       lo_q;
  logic [SUM_W-1:0] word;
  logic [SUM_W-1:0] dbl;
  logic [SUM_W-1:0] added;
  logic [SUM_W-1:0] nxt;

  always_comb begin
    word  = {1'b0, byte_in, lo_q};
    dbl   = fold_gt({sum_q[15:0], 1'b0});
    added = dbl + word;
    nxt   = last_pair ? fold_ge(added) : fold_gt(added);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q <= '0;
      lo_q  <= '0;
    end else if (beat) begin
      if (!odd) lo_q <= byte_in;
      else      sum_q <= first_pair ? word : nxt;
    end
  end

  assign sum_o = sum_q[15:0];

  // R7: the running sum always stays within the modulus
  p_sum_range_r7: assert property (@(posedge clk) disable iff (rst)
    sum_q <= SUM_MOD);

endmodule

// File: rtl/station_addr_rom_check.sv
module station_addr_rom_check #(
  parameter int PAT_LEN    = 8,
  parameter int HUNT_MAX   = 32,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    skip_sync,
  input  logic                    rd_ack,
  input  logic [7:0]              rd_data,
  output logic                    rd_req,
  output logic                    done,
  output logic                    valid,
  output logic [ADDR_BYTES*8-1:0] mac_addr
);
  import sar_pkg::*;

  localparam int MAC_W = ADDR_BYTES * 8;
  localparam int BI_W  = $clog2(ADDR_BYTES);

  sar_state_e      state_q;
  logic [BI_W-1:0] bidx_q;
  logic            chi_q;
  logic [7:0]      clo_q;
  logic            beat;
  logic            accept;
  logic            found;
  logic            exhausted;
  logic [15:0]     sum;
  logic            grp_bit;
  logic            oui_zero;

  assign beat     = rd_req && rd_ack;
  assign accept   = start && (state_q == ST_IDLE);
  assign grp_bit  = mac_addr[MAC_W-8];
  assign oui_zero = (mac_addr[MAC_W-1 -: 24] == 24'd0);

  sar_sync_hunt #(.PAT_LEN(PAT_LEN), .HUNT_MAX(HUNT_MAX)) hunt_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .beat     (beat && (state_q == ST_HUNT)),
    .byte_in  (rd_data),
    .found    (found),
    .exhausted(exhausted)
  );

  sar_cksum_fold fold_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (accept),
    .beat      (beat && (state_q == ST_ADDR)),
    .odd       (bidx_q[0]),
    .first_pair(bidx_q == BI_W'(1)),
    .last_pair (bidx_q == BI_W'(ADDR_BYTES - 1)),
    .byte_in   (rd_data),
    .sum_o     (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      bidx_q   <= '0;
      chi_q    <= 1'b0;
      clo_q    <= '0;
      rd_req   <= 1'b0;
      done     <= 1'b0;
      valid    <= 1'b0;
      mac_addr <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            valid   <= 1'b0;
            bidx_q  <= '0;
            chi_q   <= 1'b0;
            rd_req  <= 1'b1;
            state_q <= skip_sync ? ST_ADDR : ST_HUNT;
          end
        end
        ST_HUNT: begin
          if (found) begin
            state_q <= ST_ADDR;
          end else if (exhausted) begin
            state_q <= ST_IDLE;
            rd_req  <= 1'b0;
            done    <= 1'b1;
            valid   <= 1'b0;
          end
        end
        ST_ADDR: begin
          if (beat) begin
            mac_addr[(ADDR_BYTES - 1 - int'(bidx_q)) * 8 +: 8] <= rd_data;
            if (bidx_q == BI_W'(ADDR_BYTES - 1)) state_q <= ST_CSUM;
            else                                 bidx_q  <= bidx_q + 1'b1;
          end
        end
        default: begin
          if (beat) begin
            if (!chi_q) begin
              clo_q <= rd_data;
              chi_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
              rd_req  <= 1'b0;
              done    <= 1'b1;
              valid   <= (sum == {rd_data, clo_q}) && !grp_bit && !oui_zero;
            end
          end
        end
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: no request outstanding while completing
  p_done_noreq_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req);

  // R2: idle block never requests
  p_idle_noreq_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !rd_req);

  // R10: results hold while idle and no start arrives
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start) |=> ($stable(valid) && $stable(mac_addr)));

  // R9: an accepted address never carries the group bit
  p_no_group_r9: assert property (@(posedge clk) disable iff (rst)
    (done && valid) |-> !mac_addr[MAC_W-8]);

  // R9: an accepted address never has an all-zero prefix
  p_no_zero_oui_r9: assert property (@(posedge clk) disable iff (rst)
    (done && valid) |-> (mac_addr[MAC_W-1 -: 24] != 24'd0));

endmodule

// File: tb/station_addr_rom_check_tb.sv
module station_addr_rom_check_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        skip_sync = 1'b0;
  logic        rd_ack = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        rd_req;
  logic        done;
  logic        valid;
  logic [47:0] mac_addr;

  station_addr_rom_check dut_i (
    .clk(clk), .rst(rst), .start(start), .skip_sync(skip_sync),
    .rd_ack(rd_ack), .rd_data(rd_data), .rd_req(rd_req),
    .done(done), .valid(valid), .mac_addr(mac_addr)
  );

  always #4 clk = ~clk;   // 125 MHz

  logic [7:0] rom [0:63];
  int nreads = 0;
  int base   = 0;
  int tests  = 0;
  int fails  = 0;
  int cycles = 0;

  // ROM model: present the next byte whenever a request is seen
  always @(negedge clk) begin
    rd_ack  = rd_req;
    rd_data = rom[(nreads - base) & 63];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rd_req && rd_ack) nreads <= nreads + 1;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pat(input int i);
    case (i % 4)
      0: return 8'hFF;
      1: return 8'h00;
      2: return 8'h55;
      default: return 8'hAA;
    endcase
  endfunction

  function automatic int model_sum(input int p);
    int s;
    s = rom[p] | (rom[p+1] << 8);
    for (int k = 1; k < 3; k++) begin
      s = s * 2;
      if (s > 65535) s = s - 65535;
      s = s + (rom[p+2*k] | (rom[p+2*k+1] << 8));
      if (k < 2 && s > 65535) s = s - 65535;
    end
    if (s >= 65535) s = s - 65535;
    return s;
  endfunction

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 64; i++) rom[i] = v;
  endtask

  task automatic put_sync(input int at);
    for (int i = 0; i < 8; i++) rom[at+i] = 8'(pat(i));
  endtask

  task automatic put_rec(input int at, input logic [47:0] m, input bit good);
    int s;
    for (int i = 0; i < 6; i++) rom[at+i] = m[47-8*i -: 8];
    s = model_sum(at);
    if (!good) s = s ^ 1;
    rom[at+6] = 8'(s & 255);
    rom[at+7] = 8'((s >> 8) & 255);
  endtask

  task automatic run_case(input string req, input bit skip, input bit poke);
    int pos, exp_reads, idx, s;
    bit exp_valid, seen;
    logic [47:0] exp_mac, hold_mac;
    logic hold_valid;
    pos = -1;
    exp_mac = '0;
    if (skip) pos = 0;
    else begin
      idx = 0;
      for (int i = 0; i < 32 && pos < 0; i++) begin
        if (int'(rom[i]) == pat(idx)) begin
          idx++;
          if (idx == 8) pos = i + 1;
        end else idx = 0;
      end
    end
    if (pos < 0) begin
      exp_reads = 32;
      exp_valid = 0;
    end else begin
      exp_reads = pos + 8;
      for (int i = 0; i < 6; i++) exp_mac[47-8*i -: 8] = rom[pos+i];
      s = model_sum(pos);
      exp_valid = (s == (rom[pos+6] | (rom[pos+7] << 8))) && !rom[pos][0]
                  && !(rom[pos] == 0 && rom[pos+1] == 0 && rom[pos+2] == 0);
    end
    @(negedge clk);
    base = nreads;
    skip_sync = skip;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int k = 0; k < 200 && !seen; k++) begin
      if (done) seen = 1;
      else begin
        start = poke && (k == 3);
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk(req, "done seen", 64'(seen), 64'd1);
    chk(req, "valid", 64'(valid), 64'(exp_valid));
    chk("R2", "bytes read", 64'(nreads - base), 64'(exp_reads));
    if (pos >= 0) chk("R6", "mac_addr", 64'(mac_addr), 64'(exp_mac));
    hold_valid = valid;
    hold_mac = mac_addr;
    repeat (3) @(negedge clk);
    chk("R10", "done one cycle", 64'(done), 64'd0);
    chk("R10", "valid held", 64'(valid), 64'(hold_valid));
    chk("R10", "mac held", 64'(mac_addr), 64'(hold_mac));
    chk("R2", "req low after done", 64'(rd_req), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "valid", 64'(valid), 64'd0);
    chk("R1", "rd_req", 64'(rd_req), 64'd0);
    chk("R1", "mac_addr", 64'(mac_addr), 64'd0);
  endtask

  task automatic t_basic;       // R3 R6 R7 R8
    fill(8'h11); put_sync(3); put_rec(11, 48'h02_1A_2B_3C_4D_5E, 1);
    run_case("R3", 0, 0);
  endtask

  task automatic t_skip;        // R5
    fill(8'h11); put_rec(0, 48'hA4_C3_90_12_77_E1, 1);
    run_case("R5", 1, 0);
  endtask

  task automatic t_bad_sum;     // R8
    fill(8'h11); put_sync(0); put_rec(8, 48'h08_00_2B_01_02_03, 0);
    run_case("R8", 0, 0);
  endtask

  task automatic t_group;       // R9
    fill(8'h11); put_sync(2); put_rec(10, 48'h03_44_55_66_77_88, 1);
    run_case("R9", 0, 0);
  endtask

  task automatic t_zero_oui;    // R9
    fill(8'h11); put_sync(0); put_rec(8, 48'h00_00_00_12_34_56, 1);
    run_case("R9", 0, 0);
  endtask

  task automatic t_no_sync;     // R4
    fill(8'h11);
    run_case("R4", 0, 0);
  endtask

  task automatic t_edge_sync;   // R4: last pattern byte is the 32nd read
    fill(8'h11); put_sync(24); put_rec(32, 48'h00_1B_21_AA_BB_CC, 1);
    run_case("R4", 0, 0);
  endtask

  task automatic t_late_sync;   // R4: pattern ends on the 33rd read
    fill(8'h11); put_sync(25); put_rec(33, 48'h00_1B_21_AA_BB_CC, 1);
    run_case("R4", 0, 0);
  endtask

  task automatic t_false_start; // R3: mismatching FF is not re-tested
    fill(8'h11);
    rom[0] = 8'hFF; rom[1] = 8'h00; rom[2] = 8'h55; rom[3] = 8'hAA;
    rom[4] = 8'hFF;
    put_sync(5);
    put_rec(13, 48'h02_11_22_33_44_55, 1);
    run_case("R3", 0, 0);
  endtask

  task automatic t_fold;        // R7: final sum equals 65535 and folds to 0
    fill(8'h11); put_sync(0); put_rec(8, 48'h00_80_FF_7F_FE_FF, 1);
    chk("R7", "model fold", 64'(rom[14] | (rom[15] << 8)), 64'd0);
    run_case("R7", 0, 0);
  endtask

  task automatic t_busy;        // R10: start during a run is ignored
    fill(8'h11); put_sync(4); put_rec(12, 48'h5C_26_0A_01_02_03, 1);
    run_case("R10", 0, 1);
  endtask

  initial begin
    fill(8'h11);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_skip();
    t_bad_sum();
    t_group();
    t_zero_oui();
    t_no_sync();
    t_edge_sync();
    t_late_sync();
    t_false_start();
    t_fold();
    t_busy();
    t_basic();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule